// File: doc/BRIEF.md
# TLB Fault Capture and Refill Set Picker

This block sits beside a set-associative TLB. On each translation fault it records two software-visible registers. One register says which TLB slot software should rewrite: the index and the set. The other records why the fault happened: the process ID, the kind of access and the faulting virtual page number.

A 16-bit pseudo-random shift register chooses the set for a refill. It steps once per real fault. Debug probes that fault leave all state untouched.

When the TLB reports a miss, the set written to the select register is the random one, taken before the shift register steps. When the TLB hit but the access was refused (a protection or invalid fault), the set that hit is reported instead. The current random set is also driven out continuously so the refill path can use it.

Top module: `tlbf_fault_capture`

## Requirements
- R1: While `rst_ni` is low, and after its release, the random state is 0xCCCC, so `repl_set_o` is 0. `sel_o` and `cause_o` are 0.
- R2: A fault (`fault_i`=1, `probe_i`=0) at a rising edge steps the random state. The new bit 15 is the parity of (state AND 0x8805), and bits [14:0] take the old bits [15:1]. `repl_set_o` always shows state bits [1:0].
- R3: A fault with `probe_i`=1 changes nothing: not the random state, not `sel_o`, not `cause_o`.
- R4: In a cycle with `fault_i`=0, `sel_o`, `cause_o` and `repl_set_o` keep their values.
- R5: On a fault, `sel_o` is rewritten as a whole. Bits [3:0] hold `vpn_i[3:0]`, bits [5:4] hold the set, and bits [31:6] are 0.
- R6: On a fault with `miss_i`=1, the set is `repl_set_o` as it was in the fault cycle, before the step.
- R7: On a fault with `miss_i`=0, the set is `hit_set_i`, whatever the random state is.
- R8: On a fault, `cause_o[7:0]` takes `pid_i`, `cause_o[9:8]` takes `cause_i` (0 read, 1 write, 2 execute), and `cause_o[31:13]` takes `vpn_i`. Bits [12:10] keep their previous value, which is 0 from reset.
- R9: Every register update is visible after the rising edge at which `fault_i` is sampled high. Back-to-back faults each update once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_i | input | 1 | Fault strobe, one cycle per fault |
| probe_i | input | 1 | Access is a debug probe; suppresses all updates |
| vpn_i | input | 19 | Faulting virtual page number |
| pid_i | input | 8 | Current process ID |
| cause_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| miss_i | input | 1 | 1 = no TLB entry matched, 0 = matched but refused |
| hit_set_i | input | 2 | Set that matched when `miss_i` is 0 |
| sel_o | output | 32 | TLB-select register |
| cause_o | output | 32 | Fault-cause register |
| repl_set_o | output | 2 | Current replacement set (random state bits [1:0]) |

## Verification
The assertions check several rules on every cycle: all state holds when there is no fault and on probe faults, the random state never becomes zero, and the reported set follows the miss or hit source. They also check that the page number lands in the cause register. The bench's reference model of the shift register is the only check of the exact random sequence from 0xCCCC over long runs. The bench scenarios also cover the cleared upper select bits, the preserved reserved cause bits, and back-to-back fault strings mixed with probes.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned LFSR_W    = 16;
  localparam logic [15:0] LFSR_SEED = 16'hCCCC;
  localparam logic [15:0] LFSR_TAPS = 16'h8805;
  localparam int unsigned VPN_W     = 19;
  localparam int unsigned PID_W     = 8;
  localparam int unsigned CODE_W    = 2;
  localparam int unsigned IDX_W     = 4;
  localparam int unsigned SET_W     = 2;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } acc_code_e;
endpackage

// File: rtl/tlbf_lfsr.sv
module tlbf_lfsr #(
  parameter int unsigned W         = 16,
  parameter logic [W-1:0] SEED     = 16'hCCCC,
  parameter logic [W-1:0] TAPS     = 16'h8805
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] tap_bits;
  logic         fb;

  for (genvar g = 0; g < W; g++) begin : g_tap
    if (TAPS[g]) begin : g_on
      assign tap_bits[g] = state_q[g];
    end else begin : g_off
      assign tap_bits[g] = 1'b0;
    end
  end

  assign fb = ^tap_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (step_i) state_q <= {fb, state_q[W-1:1]};
  end

  assign state_o = state_q;

  a_r4_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(state_q));
  a_r2_never_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/tlbf_sel_reg.sv
module tlbf_sel_reg #(
  parameter int unsigned REG_W = 32,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned SET_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [SET_W-1:0] set_i,
  output logic [REG_W-1:0] sel_o
);
  localparam int unsigned USED_W = IDX_W + SET_W;

  logic [REG_W-1:0] sel_q;
  logic [REG_W-1:0] sel_d;

  // whole register is rewritten: unused bits clear on every load
  always_comb begin
    sel_d = '0;
    sel_d[USED_W-1:0] = {set_i, idx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (load_i) sel_q <= sel_d;
  end

  assign sel_o = sel_q;

  a_r5_idx_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> sel_q[IDX_W-1:0] == $past(idx_i));
endmodule

// File: rtl/tlbf_cause_reg.sv
module tlbf_cause_reg #(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned PID_W  = 8,
  parameter int unsigned CODE_W = 2,
  parameter int unsigned VPN_W  = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PID_W-1:0]  pid_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [VPN_W-1:0]  vpn_i,
  output logic [REG_W-1:0]  cause_o
);
  localparam int unsigned CODE_LSB = PID_W;
  localparam int unsigned VPN_LSB  = REG_W - VPN_W;
  localparam int unsigned RSV_LSB  = CODE_LSB + CODE_W;

  logic [REG_W-1:0] cause_q;

  // bits between code and vpn are never loaded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
    end else if (load_i) begin
      cause_q[PID_W-1:0]               <= pid_i;
      cause_q[CODE_LSB+CODE_W-1:CODE_LSB] <= code_i;
      cause_q[REG_W-1:VPN_LSB]         <= vpn_i;
    end
  end

  assign cause_o = cause_q;

  a_r8_vpn_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cause_q[REG_W-1:VPN_LSB] == $past(vpn_i));
  a_r8_rsv_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(cause_q[VPN_LSB-1:RSV_LSB]));
endmodule

// File: rtl/tlbf_fault_capture.sv
module tlbf_fault_capture
  import tlbf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_i,
  input  logic              probe_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [PID_W-1:0]  pid_i,
  input  logic [CODE_W-1:0] cause_i,
  input  logic              miss_i,
  input  logic [SET_W-1:0]  hit_set_i,
  output logic [REG_W-1:0]  sel_o,
  output logic [REG_W-1:0]  cause_o,
  output logic [SET_W-1:0]  repl_set_o
);
  logic              take;
  logic [LFSR_W-1:0] lfsr_state;
  logic [SET_W-1:0]  set_pick;

  assign take       = fault_i & ~probe_i;
  assign repl_set_o = lfsr_state[SET_W-1:0];
  // random set is sampled before the step lands
  assign set_pick   = miss_i ? repl_set_o : hit_set_i;

  tlbf_lfsr #(
    .W    (LFSR_W),
    .SEED (LFSR_SEED),
    .TAPS (LFSR_TAPS)
  ) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (take),
    .state_o (lfsr_state)
  );

  tlbf_sel_reg #(
    .REG_W (REG_W),
    .IDX_W (IDX_W),
    .SET_W (SET_W)
  ) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (take),
    .idx_i  (vpn_i[IDX_W-1:0]),
    .set_i  (set_pick),
    .sel_o  (sel_o)
  );

  tlbf_cause_reg #(
    .REG_W  (REG_W),
    .PID_W  (PID_W),
    .CODE_W (CODE_W),
    .VPN_W  (VPN_W)
  ) u_cause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (take),
    .pid_i   (pid_i),
    .code_i  (cause_i),
    .vpn_i   (vpn_i),
    .cause_o (cause_o)
  );

  a_r3_probe_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i && probe_i |=> $stable(sel_o) && $stable(cause_o) && $stable(repl_set_o));
  a_r4_idle_regs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_i |=> $stable(sel_o) && $stable(cause_o));
  a_r6_miss_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i && !probe_i && miss_i |=> sel_o[IDX_W+SET_W-1:IDX_W] == $past(repl_set_o));
  a_r7_hit_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i && !probe_i && !miss_i |=> sel_o[IDX_W+SET_W-1:IDX_W] == $past(hit_set_i));
endmodule

// File: tb/sim_tlbf_fault_capture.sv
module sim_tlbf_fault_capture;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fault_i = 1'b0;
  logic        probe_i = 1'b0;
  logic [18:0] vpn_i = '0;
  logic [7:0]  pid_i = '0;
  logic [1:0]  cause_i = '0;
  logic        miss_i = 1'b0;
  logic [1:0]  hit_set_i = '0;
  logic [31:0] sel_o;
  logic [31:0] cause_o;
  logic [1:0]  repl_set_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [15:0] m_lfsr;
  logic [31:0] m_sel;
  logic [31:0] m_cause;

  always #2 clk_i = ~clk_i;

  tlbf_fault_capture u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .fault_i(fault_i), .probe_i(probe_i),
    .vpn_i(vpn_i), .pid_i(pid_i), .cause_i(cause_i), .miss_i(miss_i),
    .hit_set_i(hit_set_i), .sel_o(sel_o), .cause_o(cause_o), .repl_set_o(repl_set_o)
  );

  function automatic logic [15:0] lfsr_next(logic [15:0] s);
    return {^(s & 16'h8805), s[15:1]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk({req, " sel"},   sel_o,   m_sel);
    chk({req, " cause"}, cause_o, m_cause);
    chk({req, " repl"},  {30'd0, repl_set_o}, {30'd0, m_lfsr[1:0]});
  endtask

  // one cycle: drive after negedge, sample 1ns after posedge
  task automatic cyc(bit f, bit p, logic [18:0] v, logic [7:0] pid, logic [1:0] c,
                     bit miss, logic [1:0] hs, string req);
    @(negedge clk_i);
    fault_i = f; probe_i = p; vpn_i = v; pid_i = pid; cause_i = c;
    miss_i = miss; hit_set_i = hs;
    @(posedge clk_i);
    #1;
    if (f && !p) begin
      m_sel   = {26'd0, (miss ? m_lfsr[1:0] : hs), v[3:0]};
      m_cause = {v, m_cause[12:10], c, pid};
      m_lfsr  = lfsr_next(m_lfsr);
    end
    check_all(req);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_lfsr = 16'hCCCC; m_sel = '0; m_cause = '0;
    #7;
    check_all("R1 in reset");
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check_all("R1 after release");

    // R6 miss from seed: set = 0xCCCC[1:0] = 0
    cyc(1, 0, 19'h5A5A3, 8'h3C, 2'd0, 1, 2'd3, "R6 miss read");
    // R7 hit refused write: set from hit_set_i
    cyc(1, 0, 19'h7FFFF, 8'hFF, 2'd1, 0, 2'd2, "R7 hit write");
    // R3 probe faults change nothing
    cyc(1, 1, 19'h12345, 8'h11, 2'd2, 1, 2'd1, "R3 probe miss");
    cyc(1, 1, 19'h00001, 8'h22, 2'd0, 0, 2'd3, "R3 probe hit");
    // R4 idle cycles with junk inputs
    cyc(0, 0, 19'h2AAAA, 8'h99, 2'd2, 1, 2'd1, "R4 idle");
    cyc(0, 1, 19'h15555, 8'h66, 2'd1, 0, 2'd0, "R4 idle probe");
    // R8 execute code, R5 zero page
    cyc(1, 0, 19'h00000, 8'h00, 2'd2, 0, 2'd1, "R8 exec");
    chk("R5 upper clear", {6'd0, sel_o[31:6]}, 32'd0);
    chk("R8 reserved bits", {29'd0, cause_o[12:10]}, 32'd0);
    // R9 back-to-back miss string, R2 stepping
    for (int i = 0; i < 20; i++)
      cyc(1, 0, 19'(i * 7 + 3), 8'(i), 2'(i % 3), 1, 2'd0, "R9 burst");
    chk("R2 repl after burst", {30'd0, repl_set_o}, {30'd0, m_lfsr[1:0]});

    // random mix
    for (int i = 0; i < 2000; i++) begin
      automatic int r = $urandom_range(0, 9);
      cyc(r < 6, r == 5, 19'($urandom), 8'($urandom), 2'($urandom_range(0, 2)),
          1'($urandom), 2'($urandom), (r == 5) ? "R3 rand probe" :
          (r < 5) ? "R2 rand fault" : "R4 rand idle");
    end
    chk("R8 reserved end", {29'd0, cause_o[12:10]}, 32'd0);

    // R1 reset again mid-run
    @(negedge clk_i); rst_ni = 1'b0; fault_i = 1'b0;
    #1;
    m_lfsr = 16'hCCCC; m_sel = '0; m_cause = '0;
    check_all("R1 re-reset");
    @(negedge clk_i); rst_ni = 1'b1;
    cyc(1, 0, 19'h4000F, 8'hA5, 2'd1, 1, 2'd3, "R6 miss after reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule